// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general-purpose registers of a 32-bit core whose visible register set depends on the current operating mode. Two read ports and one write port each take a 4-bit logical register number. A 5-bit mode input steers every access to the right physical copy. Low registers are shared by all modes. The fast-interrupt mode has a private copy of the upper general registers. Each exception mode has its own stack pointer and link register. User and system modes share one set.

The block also stores one saved-status word per exception mode. This word is reached through a dedicated status port in the current mode. An extra entry port writes the link register and saved-status word of a named target mode in a single cycle, which is what the exception-entry sequence needs. The program counter is held elsewhere. Logical register 15 is not stored: it reads as zero and its writes are dropped.

Top module: `banked_regfile`

## Requirements
- R1: The mode input decodes as follows: 10000 user, 10001 fast interrupt, 10010 normal interrupt, 10011 supervisor, 10111 abort, 11011 undefined, 11111 system. System mode and every unlisted value use the user bank.
- R2: Logical registers 0 to 7 have one physical copy. A write in any mode is visible in every mode.
- R3: Logical registers 8 to 12 have a private copy in fast-interrupt mode. All other modes share a second copy.
- R4: Logical registers 13 and 14 have a private pair in each of the five exception modes. User and system modes share one pair.
- R5: Each exception mode has its own saved-status word. The status port reads and writes the word of the current mode.
- R6: In user mode, system mode or an unlisted mode, the status port reads zero and a status write changes nothing.
- R7: Logical register 15 reads as zero on both read ports. A write to it changes no stored register.
- R8: Reads are combinational. Writes take effect at the rising clock edge, so a read of a register being written in the same cycle returns the old value.
- R9: When the entry port is enabled, it writes the link register (logical 14) and the saved-status word of the target mode at the edge. The status part is dropped for user-bank targets. The entry port wins over the write port and the status port when both hit the same storage in the same cycle.
- R10: A synchronous reset clears every stored register and saved-status word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 5 | Current operating mode |
| rd_a_idx | input | 4 | Logical register for read port A |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 4 | Logical register for read port B |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Write enable of the general write port |
| wr_idx | input | 4 | Logical register to write |
| wr_data | input | DW | Write data |
| sts_rd_data | output | DW | Saved-status word of the current mode |
| sts_wr_en | input | 1 | Write enable for the current mode's saved-status word |
| sts_wr_data | input | DW | Saved-status write data |
| ent_en | input | 1 | Exception-entry write enable |
| ent_mode_i | input | 5 | Target mode of the entry write |
| ent_link_i | input | DW | Value for the target mode's link register |
| ent_status_i | input | DW | Value for the target mode's saved-status word |

## Verification
The properties assume that every input carries a known value at each rising edge and that reset is held for the first edge. The write-then-read properties compare a port read against data written one cycle earlier, so they rely on the mode staying the same, or on the read landing in storage that every mode shares. The bench changes all inputs only at falling edges. It holds the mode steady across each write and the read that follows it. The properties that mention a mode change simply step aside in those cycles.

// File: rtl/bank_pkg.sv
package bank_pkg;

    // Register-bank classes reached through the mode input
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    localparam logic [4:0] MD_USR = 5'b10000;
    localparam logic [4:0] MD_FIQ = 5'b10001;
    localparam logic [4:0] MD_IRQ = 5'b10010;
    localparam logic [4:0] MD_SVC = 5'b10011;
    localparam logic [4:0] MD_ABT = 5'b10111;
    localparam logic [4:0] MD_UND = 5'b11011;
    localparam logic [4:0] MD_SYS = 5'b11111;

    localparam int NUM_BANKS  = 6;
    localparam int NUM_LOW    = 8;               // shared 0..7
    localparam int NUM_HIGH   = 5;               // 8..12
    localparam int HIGH_COM   = NUM_LOW;         // common copy of 8..12
    localparam int HIGH_FIQ   = NUM_LOW + NUM_HIGH;
    localparam int PAIR_BASE  = NUM_LOW + 2 * NUM_HIGH;
    localparam int NUM_PHYS   = PAIR_BASE + 2 * NUM_BANKS;
    localparam int NUM_SAVED  = NUM_BANKS - 1;
    localparam int PHYS_W     = $clog2(NUM_PHYS);
    localparam int SAVED_W    = $clog2(NUM_BANKS);

endpackage

// File: rtl/bank_sel.sv
module bank_sel
    import bank_pkg::*;
(
    input  logic [4:0] mode,
    output bank_e      bank
);

    always_comb begin
        case (mode)
            MD_FIQ:  bank = BK_FIQ;
            MD_IRQ:  bank = BK_IRQ;
            MD_SVC:  bank = BK_SVC;
            MD_ABT:  bank = BK_ABT;
            MD_UND:  bank = BK_UND;
            default: bank = BK_USR;   // user, system and unlisted values
        endcase
    end

endmodule

// File: rtl/reg_locate.sv
module reg_locate
    import bank_pkg::*;
(
    input  logic [3:0]        reg_idx,
    input  bank_e             bank,
    output logic              hit,
    output logic [PHYS_W-1:0] phys
);

    always_comb begin
        int r;
        int slot;
        r    = int'(reg_idx);
        hit  = 1'b1;
        slot = 0;
        if (r < NUM_LOW) begin
            slot = r;
        end else if (r < NUM_LOW + NUM_HIGH) begin
            slot = (bank == BK_FIQ ? HIGH_FIQ : HIGH_COM) + (r - NUM_LOW);
        end else if (r < 15) begin
            slot = PAIR_BASE + 2 * int'(bank) + (r - 13);
        end else begin
            hit  = 1'b0;   // logical 15 lives outside this block
        end
        phys = PHYS_W'(slot);
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [4:0]    mode_i,
    input  logic [3:0]    rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    input  logic [3:0]    rd_b_idx,
    output logic [DW-1:0] rd_b_data,
    input  logic          wr_en,
    input  logic [3:0]    wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] sts_rd_data,
    input  logic          sts_wr_en,
    input  logic [DW-1:0] sts_wr_data,
    input  logic          ent_en,
    input  logic [4:0]    ent_mode_i,
    input  logic [DW-1:0] ent_link_i,
    input  logic [DW-1:0] ent_status_i
);

    typedef struct packed {
        logic [NUM_PHYS-1:0][DW-1:0]  gpr;
        logic [NUM_SAVED-1:0][DW-1:0] saved;
    } store_t;

    store_t store_d, store_q;

    bank_e cur_bank, ent_bank;

    bank_sel u_cur_sel (.mode(mode_i),     .bank(cur_bank));
    bank_sel u_ent_sel (.mode(ent_mode_i), .bank(ent_bank));

    logic              ra_hit, rb_hit, wr_hit, el_hit;
    logic [PHYS_W-1:0] ra_phys, rb_phys, wr_phys, el_phys;

    reg_locate u_loc_ra (.reg_idx(rd_a_idx), .bank(cur_bank), .hit(ra_hit), .phys(ra_phys));
    reg_locate u_loc_rb (.reg_idx(rd_b_idx), .bank(cur_bank), .hit(rb_hit), .phys(rb_phys));
    reg_locate u_loc_wr (.reg_idx(wr_idx),   .bank(cur_bank), .hit(wr_hit), .phys(wr_phys));
    reg_locate u_loc_el (.reg_idx(4'd14),    .bank(ent_bank), .hit(el_hit), .phys(el_phys));

    // Saved-status slot: exception bank number minus one
    logic [SAVED_W-1:0] cur_slot, ent_slot;
    logic               cur_has_sts, ent_has_sts;

    always_comb begin
        cur_has_sts = (cur_bank != BK_USR);
        ent_has_sts = (ent_bank != BK_USR);
        cur_slot    = SAVED_W'(cur_bank) - SAVED_W'(1);
        ent_slot    = SAVED_W'(ent_bank) - SAVED_W'(1);
    end

    // Next-state: entry port applied last so it takes priority
    always_comb begin
        store_d = store_q;
        if (rst) begin
            store_d = '0;
        end else begin
            if (wr_en && wr_hit) begin
                store_d.gpr[wr_phys] = wr_data;
            end
            if (sts_wr_en && cur_has_sts) begin
                store_d.saved[cur_slot] = sts_wr_data;
            end
            if (ent_en) begin
                if (el_hit) begin
                    store_d.gpr[el_phys] = ent_link_i;
                end
                if (ent_has_sts) begin
                    store_d.saved[ent_slot] = ent_status_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        store_q <= store_d;
    end

    always_comb begin
        rd_a_data   = ra_hit      ? store_q.gpr[ra_phys]    : '0;
        rd_b_data   = rb_hit      ? store_q.gpr[rb_phys]    : '0;
        sts_rd_data = cur_has_sts ? store_q.saved[cur_slot] : '0;
    end

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
    import bank_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [4:0]    mode_i,
    input logic [3:0]    rd_a_idx,
    input logic [DW-1:0] rd_a_data,
    input logic [3:0]    rd_b_idx,
    input logic [DW-1:0] rd_b_data,
    input logic          wr_en,
    input logic [3:0]    wr_idx,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] sts_rd_data,
    input logic          sts_wr_en,
    input logic [DW-1:0] sts_wr_data,
    input logic          ent_en,
    input logic [4:0]    ent_mode_i,
    input logic [DW-1:0] ent_link_i,
    input logic [DW-1:0] ent_status_i
);

    logic cur_exc;
    always_comb begin
        cur_exc = (mode_i == MD_FIQ) || (mode_i == MD_IRQ) || (mode_i == MD_SVC) ||
                  (mode_i == MD_ABT) || (mode_i == MD_UND);
    end

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0 && sts_rd_data == '0));

    // R7
    no_pc_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == 4'hF) |-> (rd_a_data == '0));

    // R6
    no_user_status_chk: assert property (@(posedge clk) disable iff (rst)
        !cur_exc |-> (sts_rd_data == '0));

    // R2
    shared_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && !$past(ent_en) && $past(wr_idx) < 4'd8 &&
         rd_a_idx == $past(wr_idx)) |-> (rd_a_data == $past(wr_data)));

    // R9
    entry_link_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ent_en) && mode_i == $past(ent_mode_i) && rd_b_idx == 4'd14)
        |-> (rd_b_data == $past(ent_link_i)));

    // R5
    status_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sts_wr_en) && !$past(ent_en) && cur_exc && $stable(mode_i))
        |-> (sts_rd_data == $past(sts_wr_data)));

endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [4:0]    mode_i;
    logic [3:0]    rd_a_idx, rd_b_idx, wr_idx;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data, sts_rd_data, sts_wr_data;
    logic          wr_en, sts_wr_en, ent_en;
    logic [4:0]    ent_mode_i;
    logic [DW-1:0] ent_link_i, ent_status_i;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    banked_regfile #(.DW(DW)) i_banked_regfile (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sts_rd_data(sts_rd_data), .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
        .ent_en(ent_en), .ent_mode_i(ent_mode_i),
        .ent_link_i(ent_link_i), .ent_status_i(ent_status_i)
    );

    // Mode list: the seven named encodings, then one unlisted value
    logic [4:0] modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                              5'b10111, 5'b11011, 5'b11111, 5'b00101};

    function automatic int bank_of(int k);
        case (k)
            1: return 1;
            2: return 2;
            3: return 3;
            4: return 4;
            5: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic bit shares(int ka, int kb, int r);
        if (r < 8)  return 1'b1;
        if (r < 13) return (bank_of(ka) == 1) == (bank_of(kb) == 1);
        return bank_of(ka) == bank_of(kb);
    endfunction

    function automatic logic [DW-1:0] gval(int k, int r);
        return 32'hA000_0000 | (32'(k) << 8) | 32'(r);
    endfunction

    function automatic logic [DW-1:0] sval(int k);
        return 32'h5000_0000 | 32'(k);
    endfunction

    function automatic logic [DW-1:0] exp_gpr(int m, int r);
        logic [DW-1:0] e = '0;
        for (int k = 0; k < 8; k++) if (shares(k, m, r)) e = gval(k, r);
        return e;
    endfunction

    function automatic logic [DW-1:0] exp_sts(int m);
        logic [DW-1:0] e = '0;
        if (bank_of(m) == 0) return '0;
        for (int k = 0; k < 8; k++) if (bank_of(k) == bank_of(m)) e = sval(k);
        return e;
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; sts_wr_en = 1'b0; ent_en = 1'b0;
    endtask

    task automatic wr_gpr(logic [4:0] m, int r, logic [DW-1:0] d);
        @(negedge clk);
        mode_i = m; wr_idx = 4'(r); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        idle();
    endtask

    task automatic wr_sts(logic [4:0] m, logic [DW-1:0] d);
        @(negedge clk);
        mode_i = m; sts_wr_data = d; sts_wr_en = 1'b1;
        @(negedge clk);
        idle();
    endtask

    task automatic look(logic [4:0] m, int ra, int rb);
        @(negedge clk);
        mode_i = m; rd_a_idx = 4'(ra); rd_b_idx = 4'(rb);
        #1;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode_i = 5'b10000; rd_a_idx = '0; rd_b_idx = '0;
        wr_idx = '0; wr_data = '0; sts_wr_data = '0; ent_mode_i = 5'b10000;
        ent_link_i = '0; ent_status_i = '0;
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state in every mode
        for (int m = 0; m < 8; m++) begin
            for (int r = 0; r < 15; r++) begin
                look(modes[m], r, 14 - r);
                chk("R10 reset gpr", rd_a_data, '0);
            end
            chk("R10 reset status", sts_rd_data, '0);
        end

        // Fill sweep: every mode writes every register and its status word
        for (int k = 0; k < 8; k++) begin
            for (int r = 0; r < 15; r++) wr_gpr(modes[k], r, gval(k, r));
            wr_sts(modes[k], sval(k));
        end

        // R7: write to logical 15 is dropped, reads as zero
        wr_gpr(5'b10011, 15, 32'hFFFF_FFFF);
        look(5'b10011, 15, 15);
        chk("R7 port A r15", rd_a_data, '0);
        chk("R7 port B r15", rd_b_data, '0);

        // Read sweep: R1 R2 R3 R4 R5 R6 R7 (stores untouched by the r15 write)
        for (int m = 0; m < 8; m++) begin
            for (int r = 0; r < 15; r++) begin
                look(modes[m], r, 14 - r);
                if (m >= 6)       chk("R1 unlisted/system uses user bank", rd_a_data, exp_gpr(m, r));
                else if (r < 8)   chk("R2 shared low", rd_a_data, exp_gpr(m, r));
                else if (r < 13)  chk("R3 fast-interrupt high bank", rd_a_data, exp_gpr(m, r));
                else              chk("R4 per-mode sp/lr", rd_a_data, exp_gpr(m, r));
                chk("R4 port B bank view", rd_b_data, exp_gpr(m, 14 - r));
            end
            if (bank_of(m) == 0) chk("R6 status zero in user bank", sts_rd_data, '0);
            else                 chk("R5 per-mode status", sts_rd_data, exp_sts(m));
        end

        // R8: same-cycle read returns old value, new after the edge
        @(negedge clk);
        mode_i = 5'b10011; rd_a_idx = 4'd2;
        wr_idx = 4'd2; wr_data = 32'h0000_1234; wr_en = 1'b1;
        #1;
        chk("R8 old value in write cycle", rd_a_data, exp_gpr(3, 2));
        @(posedge clk); #1;
        chk("R8 new value after edge", rd_a_data, 32'h0000_1234);
        @(negedge clk);
        idle();

        // R6: status writes in user/system are dropped
        wr_sts(5'b10000, 32'hDEAD_0001);
        wr_sts(5'b11111, 32'hDEAD_0002);
        look(5'b11111, 0, 0);
        chk("R6 system status reads zero", sts_rd_data, '0);
        look(5'b10011, 0, 0);
        chk("R6 supervisor status unchanged", sts_rd_data, sval(3));
        look(5'b10001, 0, 0);
        chk("R6 fast-interrupt status unchanged", sts_rd_data, sval(1));

        // R9: entry port wins over write and status ports on the same storage
        @(negedge clk);
        mode_i = 5'b10010;
        wr_idx = 4'd14; wr_data = 32'h0000_1111; wr_en = 1'b1;
        sts_wr_data = 32'h0000_4444; sts_wr_en = 1'b1;
        ent_mode_i = 5'b10010; ent_link_i = 32'h0000_2222;
        ent_status_i = 32'h0000_3333; ent_en = 1'b1;
        @(negedge clk);
        idle();
        look(5'b10010, 14, 13);
        chk("R9 entry link priority", rd_a_data, 32'h0000_2222);
        chk("R9 entry status priority", sts_rd_data, 32'h0000_3333);
        chk("R9 irq sp untouched", rd_b_data, gval(2, 13));

        // R9: entry to another mode alongside an independent user write
        @(negedge clk);
        mode_i = 5'b10000;
        wr_idx = 4'd13; wr_data = 32'h0000_7777; wr_en = 1'b1;
        ent_mode_i = 5'b11011; ent_link_i = 32'h0000_8888;
        ent_status_i = 32'h0000_9999; ent_en = 1'b1;
        @(negedge clk);
        idle();
        look(5'b10000, 13, 14);
        chk("R9 user sp written alongside entry", rd_a_data, 32'h0000_7777);
        chk("R9 user lr untouched", rd_b_data, exp_gpr(0, 14));
        look(5'b11011, 14, 13);
        chk("R9 undefined lr via entry", rd_a_data, 32'h0000_8888);
        chk("R9 undefined status via entry", sts_rd_data, 32'h0000_9999);

        // R9: entry to system writes user-bank link, status dropped
        @(negedge clk);
        ent_mode_i = 5'b11111; ent_link_i = 32'h0000_ABCD;
        ent_status_i = 32'h0000_EEEE; ent_en = 1'b1;
        @(negedge clk);
        idle();
        look(5'b10000, 14, 0);
        chk("R9 system entry writes shared lr", rd_a_data, 32'h0000_ABCD);
        chk("R9 system entry status dropped", sts_rd_data, '0);
        look(5'b11011, 0, 14);
        chk("R9 undefined status kept", sts_rd_data, 32'h0000_9999);

        // R10: reset mid-run clears everything
        pulse_reset();
        for (int m = 0; m < 6; m++) begin
            for (int r = 0; r < 15; r++) begin
                look(modes[m], r, r);
                chk("R10 cleared gpr", rd_a_data, '0);
            end
            chk("R10 cleared status", sts_rd_data, '0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule